// File: doc/BRIEF.md
# Per-Warp Instruction Issue Buffer

This block sits between the decode stage and the execute stage of a multi-warp pipeline. Each decoded instruction arrives with a warp index and is stored in a small FIFO that belongs to that warp. Every cycle the block looks only at the oldest entry of each warp's FIFO. It issues the lowest-indexed warp whose oldest entry is present and has no scoreboard hazard.

The scoreboard sits outside the block. The block shows it the head entry of every warp, and the scoreboard answers with one hazard bit per warp. When an instruction issues, the block also reserves that instruction's destination register in the scoreboard, on the same cycle as the issue handshake.

Instructions are opaque words. The only field the block reads is the destination register, which sits in the low `RD_W` bits.

Top module: `warp_issue_buf`

## Requirements
- R1: After the asynchronous active-low reset, every warp buffer is empty. `query_vld_o` is all zero, `iss_valid_o` is low and `in_ready_o` is high.
- R2: `in_ready_o` is high exactly when the buffer of warp `in_wid_i` holds fewer than `DEPTH` entries, counted before any issue pop in the same cycle. A word offered while `in_ready_o` is low is not stored and must be held by decode.
- R3: Within one warp, instructions issue in the order they were accepted.
- R4: Among warps that have an entry and no hazard, the lowest warp index is issued on `iss_wid_o`. Warps with empty buffers are skipped.
- R5: A warp whose `hazard_i` bit is high is skipped, and the choice moves on to the next higher warp index.
- R6: `iss_valid_o` is high exactly when at least one warp has an entry and a low hazard bit. At most one instruction leaves per cycle.
- R7: While `iss_ready_i` is low, no entry is popped and `rsv_valid_o` stays low.
- R8: `rsv_valid_o` is high on a cycle with `iss_valid_o && iss_ready_i`. In that cycle `rsv_wid_o` equals `iss_wid_o`, and `rsv_rd_o` equals bits `[RD_W-1:0]` of `iss_instr_o`.
- R9: `query_vld_o[w]` is high exactly when warp `w` holds an entry. Slice `w` of `query_instr_o` (bits `w*INSTR_W` and up) is that warp's oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction valid |
| in_wid_i | input | WID_W | Warp index of the incoming instruction |
| in_instr_i | input | INSTR_W | Incoming instruction word |
| in_ready_o | output | 1 | Buffer of `in_wid_i` can accept |
| query_vld_o | output | NUM_WARPS | Per-warp head present |
| query_instr_o | output | NUM_WARPS*INSTR_W | Per-warp head word, shown to the scoreboard |
| hazard_i | input | NUM_WARPS | Per-warp scoreboard hazard on the head |
| iss_valid_o | output | 1 | Issue candidate present |
| iss_ready_i | input | 1 | Execute accepts |
| iss_wid_o | output | WID_W | Warp of the issued instruction |
| iss_instr_o | output | INSTR_W | Issued instruction word |
| rsv_valid_o | output | 1 | Reserve destination in scoreboard |
| rsv_wid_o | output | WID_W | Warp of the reservation |
| rsv_rd_o | output | RD_W | Destination register reserved |

## Verification
A push into a warp buffer and an issue pop from that same buffer can land on the same clock edge. This matters most when the buffer is full, because `in_ready_o` then stays low even though an entry is leaving. The bench provokes this with directed fills of one warp while execute is ready, and with long random runs that use narrow warp indices and dense valids. It judges each cycle against a queue model: the pop is applied before the push, and acceptance is computed from the occupancy before the pop.

// File: rtl/wib_pkg.sv
package wib_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wib_fifo.sv
module wib_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  localparam int PTR_W = wib_pkg::idx_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/wib_pick.sv
module wib_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // downward scan: last assignment (lowest index) wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/warp_issue_buf.sv
module warp_issue_buf #(
  parameter int NUM_WARPS = 4,
  parameter int DEPTH     = 2,
  parameter int INSTR_W   = 32,
  parameter int RD_W      = 5,
  parameter int WID_W     = wib_pkg::idx_w(NUM_WARPS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  input  logic [WID_W-1:0]             in_wid_i,
  input  logic [INSTR_W-1:0]           in_instr_i,
  output logic                         in_ready_o,
  output logic [NUM_WARPS-1:0]         query_vld_o,
  output logic [NUM_WARPS*INSTR_W-1:0] query_instr_o,
  input  logic [NUM_WARPS-1:0]         hazard_i,
  output logic                         iss_valid_o,
  input  logic                         iss_ready_i,
  output logic [WID_W-1:0]             iss_wid_o,
  output logic [INSTR_W-1:0]           iss_instr_o,
  output logic                         rsv_valid_o,
  output logic [WID_W-1:0]             rsv_wid_o,
  output logic [RD_W-1:0]              rsv_rd_o
);
  logic [NUM_WARPS-1:0] full_w, empty_w, push_w, pop_w, cand_w;
  logic [INSTR_W-1:0]   head_w [NUM_WARPS];
  logic                 fire;
  logic                 wid_ok;

  assign wid_ok     = (int'(in_wid_i) < NUM_WARPS);
  assign in_ready_o = wid_ok && !full_w[in_wid_i];
  assign fire       = iss_valid_o && iss_ready_i;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign push_w[w] = in_valid_i && in_ready_o && (in_wid_i == WID_W'(w));
    assign pop_w[w]  = fire && (iss_wid_o == WID_W'(w));
    assign cand_w[w] = !empty_w[w] && !hazard_i[w];
    assign query_vld_o[w] = !empty_w[w];
    assign query_instr_o[w*INSTR_W +: INSTR_W] = head_w[w];

    wib_fifo #(.DEPTH(DEPTH), .W(INSTR_W)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push_w[w]),
      .pop_i  (pop_w[w]),
      .din_i  (in_instr_i),
      .full_o (full_w[w]),
      .empty_o(empty_w[w]),
      .head_o (head_w[w])
    );
  end

  wib_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
    .req_i(cand_w),
    .any_o(iss_valid_o),
    .idx_o(iss_wid_o)
  );

  assign iss_instr_o = head_w[iss_wid_o];
  assign rsv_valid_o = fire;
  assign rsv_wid_o   = iss_wid_o;
  assign rsv_rd_o    = iss_instr_o[RD_W-1:0];
endmodule

// File: rtl/wib_chk.sv
module wib_chk #(
  parameter int NUM_WARPS = 4,
  parameter int INSTR_W   = 32,
  parameter int RD_W      = 5,
  parameter int WID_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WID_W-1:0]     in_wid_i,
  input logic                 in_ready_o,
  input logic [NUM_WARPS-1:0] query_vld_o,
  input logic [NUM_WARPS-1:0] hazard_i,
  input logic                 iss_valid_o,
  input logic                 iss_ready_i,
  input logic [WID_W-1:0]     iss_wid_o,
  input logic [INSTR_W-1:0]   iss_instr_o,
  input logic                 rsv_valid_o,
  input logic [WID_W-1:0]     rsv_wid_o,
  input logic [RD_W-1:0]      rsv_rd_o
);
  logic [NUM_WARPS-1:0] ready_heads;
  logic                 lower_ready;

  assign ready_heads = query_vld_o & ~hazard_i;

  always_comb begin
    lower_ready = 1'b0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (i < int'(iss_wid_o) && ready_heads[i]) lower_ready = 1'b1;
    end
  end

  assert_full_has_head_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o && int'(in_wid_i) < NUM_WARPS) |-> query_vld_o[in_wid_i]);

  assert_lowest_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !lower_ready);

  assert_no_hazard_issue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (query_vld_o[iss_wid_o] && !hazard_i[iss_wid_o]));

  assert_issue_when_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ready_heads) |-> iss_valid_o);

  assert_no_rsv_stalled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_ready_i |-> !rsv_valid_o);

  assert_rsv_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_valid_o |-> (iss_valid_o && rsv_wid_o == iss_wid_o && rsv_rd_o == iss_instr_o[RD_W-1:0]));

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_keep
    assert_head_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (query_vld_o[w] && !(rsv_valid_o && rsv_wid_o == WID_W'(w))) |=> query_vld_o[w]);
  end
endmodule

bind warp_issue_buf wib_chk #(
  .NUM_WARPS(NUM_WARPS), .INSTR_W(INSTR_W), .RD_W(RD_W), .WID_W(WID_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_wid_i(in_wid_i), .in_ready_o(in_ready_o),
  .query_vld_o(query_vld_o), .hazard_i(hazard_i), .iss_valid_o(iss_valid_o),
  .iss_ready_i(iss_ready_i), .iss_wid_o(iss_wid_o), .iss_instr_o(iss_instr_o),
  .rsv_valid_o(rsv_valid_o), .rsv_wid_o(rsv_wid_o), .rsv_rd_o(rsv_rd_o)
);

// File: tb/sim_warp_issue_buf.sv
`timescale 1ns/1ps
module sim_warp_issue_buf;
  localparam int NW = 4, DP = 2, IW = 32, RW = 5, WW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, iss_ready = 0;
  logic [WW-1:0] in_wid = 0;
  logic [IW-1:0] in_instr = 0;
  logic [NW-1:0] hazard = 0;
  logic in_ready, iss_valid, rsv_valid;
  logic [NW-1:0] q_vld;
  logic [NW*IW-1:0] q_instr;
  logic [WW-1:0] iss_wid, rsv_wid;
  logic [IW-1:0] iss_instr;
  logic [RW-1:0] rsv_rd;

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] mq [NW][DP];
  int cnt [NW];

  always #4 clk = ~clk;

  warp_issue_buf #(.NUM_WARPS(NW), .DEPTH(DP), .INSTR_W(IW), .RD_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_wid_i(in_wid),
    .in_instr_i(in_instr), .in_ready_o(in_ready), .query_vld_o(q_vld),
    .query_instr_o(q_instr), .hazard_i(hazard), .iss_valid_o(iss_valid),
    .iss_ready_i(iss_ready), .iss_wid_o(iss_wid), .iss_instr_o(iss_instr),
    .rsv_valid_o(rsv_valid), .rsv_wid_o(rsv_wid), .rsv_rd_o(rsv_rd));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic int first_ready(input logic [NW-1:0] hz);
    for (int w = 0; w < NW; w++) if (cnt[w] > 0 && !hz[w]) return w;
    return -1;
  endfunction

  task automatic step(input logic v, input int w, input logic [IW-1:0] ins,
                      input logic [NW-1:0] hz, input logic rdy);
    int c;
    logic acc, fire;
    @(negedge clk);
    in_valid = v; in_wid = WW'(w); in_instr = ins; hazard = hz; iss_ready = rdy;
    #1;
    acc = (cnt[w] < DP);
    chk("R2 in_ready", 64'(in_ready), 64'(acc));
    for (int k = 0; k < NW; k++) begin
      chk("R9 query_vld", 64'(q_vld[k]), 64'(cnt[k] > 0));
      if (cnt[k] > 0) chk("R9 query_instr", 64'(q_instr[k*IW +: IW]), 64'(mq[k][0]));
    end
    c = first_ready(hz);
    chk("R6 iss_valid", 64'(iss_valid), 64'(c >= 0));
    fire = (c >= 0) && rdy;
    chk("R7 rsv_valid", 64'(rsv_valid), 64'(fire));
    if (c >= 0) begin
      chk("R4 R5 iss_wid", 64'(iss_wid), 64'(c));
      chk("R3 iss_instr", 64'(iss_instr), 64'(mq[c][0]));
      if (fire) begin
        chk("R8 rsv_wid", 64'(rsv_wid), 64'(c));
        chk("R8 rsv_rd", 64'(rsv_rd), 64'(mq[c][0][RW-1:0]));
      end
    end
    if (fire) begin
      for (int j = 0; j < DP - 1; j++) mq[c][j] = mq[c][j+1];
      cnt[c]--;
    end
    if (v && acc) begin
      mq[w][cnt[w]] = ins;
      cnt[w]++;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    for (int w = 0; w < NW; w++) cnt[w] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 query_vld", 64'(q_vld), 64'd0);
    chk("R1 iss_valid", 64'(iss_valid), 64'd0);
    rst_n = 1;
    // fill warp 0 beyond depth while everything hazards
    step(1, 0, 32'hA001, 4'hF, 1);
    step(1, 0, 32'hA002, 4'hF, 1);
    step(1, 0, 32'hA003, 4'hF, 1);
    // warp 0 blocked, warp 2 gets through
    step(1, 2, 32'hC011, 4'h1, 1);
    step(0, 0, 0, 4'h1, 1);
    // execute stalls: nothing leaves
    step(0, 0, 0, 4'h0, 0);
    step(0, 0, 0, 4'h0, 0);
    // full warp 0 pops while offered again: refused
    step(1, 0, 32'hA004, 4'h0, 1);
    step(0, 0, 0, 4'h0, 1);
    step(0, 0, 0, 4'h0, 1);
    for (int i = 0; i < 4000; i++) begin
      logic [NW-1:0] hz;
      hz = NW'($urandom) & NW'($urandom);
      step(($urandom % 4) != 0, int'($urandom % (i < 2000 ? 2 : NW)), $urandom,
           hz, ($urandom % 4) != 0);
    end
    repeat (12) step(0, 0, 0, 4'h0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule